// File: doc/BRIEF.md
# Timeslot Frame Serializer

This block turns a set of per-channel bytes into a single serial bit stream laid out as a repeating frame of 32 timeslots. Each timeslot is 8 bits long, so a frame is 256 bit times, one bit per clock. A free-running frame counter sets the timing. Its low bits give the bit position inside the current timeslot and its high bits give the timeslot number.

Once per timeslot, in the last bit time, the block asks for the byte of the next timeslot. It puts that timeslot's number on `chan_sel` and raises `in_ready`. The byte on `in_data` is captured at the end of that cycle. It passes through an optional zero-substitution stage and is loaded into a shift register. The register sends it most significant bit first. A one-cycle `frame_sync` pulse marks the last bit time of every frame. Frames follow each other with no gap.

The parallel input is a valid/ready stream with no back-pressure toward the serializer. The line rate is fixed, so the block never waits. `in_ready` is high for exactly one cycle per timeslot, and the source must offer its byte in that cycle. If `in_valid` is low in that cycle, an idle byte of all zeros is sent instead. Whatever is on `in_valid` and `in_data` while `in_ready` is low is ignored.

Top module: `tdm_frame_tx`

## Requirements
- R1: The frame is 256 bit times long. The frame counter runs 0..255 and wraps to 0 without a gap, so `frame_sync` pulses exactly every 256 cycles.
- R2: `chan_sel` equals (timeslot + 1) mod 32 for every cycle of a timeslot, where timeslot = count[7:3]. It therefore changes only at timeslot boundaries.
- R3: `in_ready` is high exactly in the cycles where the bit position count[2:0] equals 7. The byte is captured at the rising edge that ends that cycle.
- R4: `frame_sync` is high only in the cycle where the count equals 255. That cycle also has `in_ready` high and `chan_sel` = 0.
- R5: The captured byte appears on `ser_out` MSB first. Bit 7 appears in the cycle after the capture, followed by bits 6 down to 0, one per clock.
- R6: If `zsub_en` is high in the capture cycle, a byte of 0x00 is sent as 0x02. If `zsub_en` is low, 0x00 is sent unchanged. Non-zero bytes are never altered.
- R7: If `in_valid` is low in the capture cycle, the idle byte 0x00 is sent, and R6 still applies to it.
- R8: `in_valid` and `in_data` have no effect in cycles where `in_ready` is low.
- R9: A synchronous active-high `rst` clears the counter to 0 and the shift register to zero. In the first cycle after reset, `chan_sel` = 1, `in_ready` = 0, `frame_sync` = 0 and `ser_out` = 0. Timeslot 0 right after reset carries all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one serial bit per cycle |
| rst | input | 1 | Synchronous reset, active high |
| zsub_en | input | 1 | Enables replacing an all-zero byte with 0x02 |
| in_valid | input | 1 | Source offers a byte on `in_data` |
| in_data | input | 8 | Byte for the timeslot named by `chan_sel` |
| in_ready | output | 1 | Capture cycle: byte is taken at the end of this cycle |
| chan_sel | output | 5 | Timeslot whose byte is requested next |
| ser_out | output | 1 | Serial bit stream, MSB first |
| frame_sync | output | 1 | High during the last bit time of each frame |

## Verification
At count 255, three functions fall in the same cycle: the frame-boundary pulse, the byte request for timeslot 0 (with `chan_sel` wrapping from 31 to 0), and the load of that byte. On top of that, a zero byte offered in that cycle also brings in the substitution path. Random traffic with a high share of zero and idle bytes hits this cycle in every frame. A directed pass also forces a zero byte with substitution enabled exactly at the wrap. The bench judges each bit against a model built from the frame timing rules, and it checks the 256-cycle spacing of the sync pulses across a mid-frame reset.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  localparam int unsigned TDM_SLOTS_DEF = 32;
  localparam int unsigned TDM_BITS_DEF  = 8;
  // value sent in place of an all-zero byte: a single one at bit 1
  localparam int unsigned TDM_FILL_POS  = 1;
endpackage

// File: rtl/tdm_frame_count.sv
module tdm_frame_count #(
  parameter int unsigned SLOTS = 32,
  parameter int unsigned BITS  = 8,
  localparam int unsigned SW = $clog2(SLOTS),
  localparam int unsigned BW = $clog2(BITS),
  localparam int unsigned CW = SW + BW
) (
  input  logic          clk,
  input  logic          rst,
  output logic [SW-1:0] slot_idx,
  output logic          last_bit,
  output logic          frame_end
);
  logic [CW-1:0] cnt_q;

  assign slot_idx  = cnt_q[CW-1:BW];
  assign last_bit  = (cnt_q[BW-1:0] == BW'(BITS - 1));
  assign frame_end = (cnt_q == CW'(SLOTS * BITS - 1));

  always_ff @(posedge clk) begin
    if (rst)            cnt_q <= '0;
    else if (frame_end) cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tdm_zero_fill.sv
module tdm_zero_fill
  import tdm_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         fill_en,
  input  logic         valid,
  input  logic [W-1:0] data,
  output logic [W-1:0] word
);
  logic [W-1:0] raw;

  assign raw  = valid ? data : '0;
  assign word = (fill_en && (raw == '0)) ? W'(1 << TDM_FILL_POS) : raw;
endmodule

// File: rtl/tdm_shifter.sv
module tdm_shifter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] word_q,
  output logic         sout
);
  always_ff @(posedge clk) begin
    if (rst)       word_q <= '0;
    else if (load) word_q <= din;
    else           word_q <= {word_q[W-2:0], 1'b0};
  end

  assign sout = word_q[W-1];
endmodule

// File: rtl/tdm_frame_tx.sv
module tdm_frame_tx
  import tdm_pkg::*;
#(
  parameter int unsigned SLOTS = TDM_SLOTS_DEF,
  parameter int unsigned BITS  = TDM_BITS_DEF,
  localparam int unsigned SW = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          zsub_en,
  input  logic          in_valid,
  input  logic [BITS-1:0] in_data,
  output logic          in_ready,
  output logic [SW-1:0] chan_sel,
  output logic          ser_out,
  output logic          frame_sync
);
  logic [SW-1:0]   slot_idx;
  logic            last_bit;
  logic [BITS-1:0] fill_word;
  logic [BITS-1:0] sr_q;

  tdm_frame_count #(.SLOTS(SLOTS), .BITS(BITS)) u_cnt (
    .clk(clk), .rst(rst), .slot_idx(slot_idx),
    .last_bit(last_bit), .frame_end(frame_sync)
  );

  // request the byte of the slot that follows the current one
  assign chan_sel = (slot_idx == SW'(SLOTS - 1)) ? '0 : slot_idx + 1'b1;
  assign in_ready = last_bit;

  tdm_zero_fill #(.W(BITS)) u_fill (
    .fill_en(zsub_en), .valid(in_valid), .data(in_data), .word(fill_word)
  );

  tdm_shifter #(.W(BITS)) u_shift (
    .clk(clk), .rst(rst), .load(last_bit), .din(fill_word),
    .word_q(sr_q), .sout(ser_out)
  );
endmodule

// File: rtl/tdm_frame_tx_chk.sv
module tdm_frame_tx_chk #(
  parameter int unsigned SLOTS = 32,
  parameter int unsigned BITS  = 8,
  localparam int unsigned SW = $clog2(SLOTS)
) (
  input logic            clk,
  input logic            rst,
  input logic            zsub_en,
  input logic            in_valid,
  input logic [BITS-1:0] in_data,
  input logic            in_ready,
  input logic [SW-1:0]   chan_sel,
  input logic            ser_out,
  input logic            frame_sync,
  input logic [BITS-1:0] sr_q
);
  a_r4_sync_single: assert property (@(posedge clk) disable iff (rst)
    frame_sync |=> !frame_sync);

  a_r4_sync_at_wrap: assert property (@(posedge clk) disable iff (rst)
    frame_sync |-> (in_ready && chan_sel == '0));

  a_r3_ready_pulse: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> !in_ready);

  a_r2_sel_held: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> $stable(chan_sel));

  a_r2_sel_step: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> (chan_sel == (($past(chan_sel) == SW'(SLOTS - 1)) ? '0
                                : $past(chan_sel) + 1'b1)));

  a_r5_msb_first: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> (ser_out == $past(in_valid && in_data[BITS-1])));

  a_r6_zero_fill: assert property (@(posedge clk) disable iff (rst)
    (in_ready && zsub_en && !(in_valid && in_data != '0)) |=> (sr_q == BITS'(2)));
endmodule

bind tdm_frame_tx tdm_frame_tx_chk #(.SLOTS(SLOTS), .BITS(BITS)) u_chk (
  .clk(clk), .rst(rst), .zsub_en(zsub_en), .in_valid(in_valid),
  .in_data(in_data), .in_ready(in_ready), .chan_sel(chan_sel),
  .ser_out(ser_out), .frame_sync(frame_sync), .sr_q(sr_q)
);

// File: tb/tdm_frame_tx_tb.sv
module tdm_frame_tx_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       zsub_en;
  logic       in_valid;
  logic [7:0] in_data;
  logic       in_ready;
  logic [4:0] chan_sel;
  logic       ser_out;
  logic       frame_sync;

  int checks = 0;
  int fails  = 0;
  int cnt_m  = 0;
  logic [7:0] sr_m = 8'h00;
  int since_sync = -1;
  string ser_tag = "R5";
  bit fresh = 1'b0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  tdm_frame_tx dut_i (
    .clk(clk), .rst(rst), .zsub_en(zsub_en), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .chan_sel(chan_sel),
    .ser_out(ser_out), .frame_sync(frame_sync)
  );

  function automatic logic [7:0] sent_byte(logic z, logic v, logic [7:0] d);
    logic [7:0] b = v ? d : 8'h00;
    return (z && b == 8'h00) ? 8'h02 : b;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (count %0d)", req, act, exp, cnt_m);
    end
  endtask

  // called just after a falling edge: check outputs, drive inputs, advance model
  task automatic step(logic rs, logic z, logic v, logic [7:0] d);
    chk("R2", chan_sel, ((cnt_m / 8) + 1) % 32);
    chk("R3", in_ready, (cnt_m % 8) == 7);
    chk("R4", frame_sync, cnt_m == 255);
    chk(fresh && cnt_m < 8 ? "R9" : ser_tag, ser_out, sr_m[7]);
    if (frame_sync) begin
      if (since_sync >= 0) chk("R1", since_sync, 256);
      since_sync = 0;
    end
    if (since_sync >= 0) since_sync++;
    rst = rs; zsub_en = z; in_valid = v; in_data = d;
    if (rs) begin
      cnt_m = 0; sr_m = 8'h00; since_sync = -1; fresh = 1'b1;
    end else begin
      if (cnt_m % 8 == 7) sr_m = sent_byte(z, v, d);
      else                sr_m = {sr_m[6:0], 1'b0};
      if (cnt_m == 255) fresh = 1'b0;
      cnt_m = (cnt_m + 1) % 256;
    end
    @(negedge clk);
  endtask

  task automatic do_reset();
    step(1'b1, 1'b0, 1'b0, 8'h00);
    step(1'b1, 1'b0, 1'b0, 8'h00);
    // R9: first cycle after reset
    chk("R9", chan_sel, 1);
    chk("R9", in_ready, 0);
    chk("R9", frame_sync, 0);
    chk("R9", ser_out, 0);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; zsub_en = 1'b0; in_valid = 1'b0; in_data = 8'h00;
    @(negedge clk);
    // reset state is not modelled before the first reset: force model
    cnt_m = 0; sr_m = 8'h00;
    rst = 1'b1;
    @(negedge clk);
    do_reset();

    // random traffic, R8: junk on inputs outside capture cycles
    ser_tag = "R8";
    for (int i = 0; i < 3 * 256; i++) begin
      logic z = 1'($urandom % 2);
      logic v = ($urandom % 5) != 0;
      logic [7:0] d = ($urandom % 4 == 0) ? 8'h00 : 8'($urandom);
      step(1'b0, z, v, d);
    end

    // R6: zero byte with substitution on, then off; non-zero untouched
    ser_tag = "R6";
    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < 8; i++) begin
        logic [7:0] d = (k == 2) ? 8'h80 : (k == 3) ? 8'hFF : 8'h00;
        step(1'b0, (k != 1), 1'b1, d);
      end
    end

    // R7: idle bytes with and without substitution
    ser_tag = "R7";
    for (int i = 0; i < 32; i++) step(1'b0, 1'(i / 16), 1'b0, 8'hA5);

    // run to the frame wrap and force a zero byte there (R4 with R6)
    ser_tag = "R6";
    while (cnt_m != 255) step(1'b0, 1'b0, 1'b1, 8'($urandom));
    step(1'b0, 1'b1, 1'b1, 8'h00);
    for (int i = 0; i < 8; i++) step(1'b0, 1'b0, 1'b1, 8'($urandom));

    // R5: MSB-first patterns across consecutive slots
    ser_tag = "R5";
    for (int i = 0; i < 64; i++) begin
      logic [7:0] d = (i < 32) ? 8'h01 : 8'hC3;
      step(1'b0, 1'b0, 1'b1, d);
    end

    // mid-frame reset, then two full frames to check R1 spacing and R9
    do_reset();
    ser_tag = "R1";
    for (int i = 0; i < 600; i++) begin
      step(1'b0, 1'($urandom % 2), 1'($urandom % 2), 8'($urandom));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule